// File: doc/BRIEF.md
# Crosspoint Switch Control Register

This block holds the routing state for a switch fabric with sixteen inputs and five outputs and turns that state into closure signals for the analog matrix. Each output owns a five-bit word: a four-bit input number and a one-bit enable. A controller writes one output's word per clock through a parallel port that carries a three-bit output address. The words collect in a staging rank. A separate transfer step then copies all five staged words at once into an active rank. This lets a whole new routing pattern take effect on a single edge.

The active rank feeds five decoders. Each decoder raises exactly one of its sixteen closure lines when its output is enabled, and none when it is disabled. A chip-select input gates every write and every transfer. A disable-all input clears the five active enable bits at once, without waiting for a clock. It leaves everything else intact, so the staged pattern can be reapplied later with a single transfer. A power-on reset clears both ranks.

Top module: `xpt_ctrl`

## Requirements
- R1: After power-on reset (`por_n` low), every bit of `out_en` and `close` is 0, and both ranks hold all-zero words.
- R2: While `ce_n` is 1, a rising edge changes neither rank, whatever `xfer_n`, `addr` and `din` carry.
- R3: On a rising edge with `ce_n`=0 and `xfer_n`=1, `din` is stored as the staged word of the output numbered by `addr` (0 to 4). The other four staged words and the active rank stay unchanged.
- R4: A write with `addr` equal to 5, 6 or 7 changes no stored word.
- R5: On a rising edge with `ce_n`=0 and `xfer_n`=0, all five staged words are copied into the active rank. The outputs show the new pattern right after that edge.
- R6: On any edge without a transfer, the active rank keeps its value.
- R7: The `din` field layout is as follows. `din[3:0]` is the input number, with `din[0]` as the LSB. `din[4]` is the enable, and 1 means enabled. An enabled output k with input number s drives `close[16*k+s]`=1 and `out_en[k]`=1. At most one closure line per output is ever high.
- R8: For an output whose active enable is 0, all sixteen of its closure lines are 0.
- R9: Driving `off_n` low clears all of `out_en` and all closure lines with no clock edge. The staged words are kept.
- R10: After `off_n` returns high, the outputs stay disabled until a transfer moves a word with the enable set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for writes and transfers |
| por_n | input | 1 | Asynchronous power-on reset, active low, clears both ranks |
| off_n | input | 1 | Asynchronous disable-all, active low, clears active enables only |
| ce_n | input | 1 | Chip select, active low, gates writes and transfers |
| xfer_n | input | 1 | 1: edge writes the staged word; 0: edge transfers staged to active |
| addr | input | 3 | Output number for a write |
| din | input | 5 | Word: [4] enable, [3:0] input number |
| close | output | 80 | One-hot closure lines, bit 16*output+input |
| out_en | output | 5 | Active enable of each output |

## Verification
A corrupted staged word does not show at the ports until the next transfer, so the bench forces transfers after each write pattern. It also transfers after disable-all and ignored-address events, which exposes a wrong staging rank within one cycle. A fault in the active rank or the decoders shows on `close` and `out_en` straight after the edge that caused it. The reference model is compared on every cycle, so that fault is caught in the same cycle. The disable-all path is sampled mid-cycle, before any edge, so a clear that secretly waited for the clock would be caught.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int unsigned XP_INPUTS  = 16;
  localparam int unsigned XP_OUTPUTS = 5;
  localparam int unsigned XP_SEL_W   = $clog2(XP_INPUTS);
  localparam int unsigned XP_WORD_W  = XP_SEL_W + 1;
  localparam int unsigned XP_ADDR_W  = $clog2(XP_OUTPUTS);
  localparam int unsigned XP_CLOSE_W = XP_INPUTS * XP_OUTPUTS;

  typedef struct packed {
    logic                en;
    logic [XP_SEL_W-1:0] sel;
  } xp_word_t;

  // output address to one-hot write strobe; out-of-range codes give zero
  function automatic logic [XP_OUTPUTS-1:0] xp_addr_hit(input logic [XP_ADDR_W-1:0] a);
    logic [XP_OUTPUTS-1:0] r;
    r = '0;
    for (int i = 0; i < XP_OUTPUTS; i++)
      if (a == XP_ADDR_W'(i)) r[i] = 1'b1;
    return r;
  endfunction

  // one output's closure lines, gated by its enable
  function automatic logic [XP_INPUTS-1:0] xp_close(input xp_word_t w);
    logic [XP_INPUTS-1:0] r;
    r = '0;
    for (int i = 0; i < XP_INPUTS; i++)
      if (w.en && (w.sel == XP_SEL_W'(i))) r[i] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/xpt_stage_wr.sv
module xpt_stage_wr
  import xpt_pkg::*;
(
  input  logic                             clk,
  input  logic                             por_n,
  input  logic                             ce_n,
  input  logic                             xfer_n,
  input  logic [XP_ADDR_W-1:0]             addr,
  input  xp_word_t                         din,
  output xp_word_t [XP_OUTPUTS-1:0]        words_q
);
  logic                  wr_strobe;
  logic [XP_OUTPUTS-1:0] word_wr_en;
  logic                  addr_out_of_range;

  assign wr_strobe         = ~ce_n & xfer_n;
  assign word_wr_en        = wr_strobe ? xp_addr_hit(addr) : '0;
  assign addr_out_of_range = (addr >= XP_ADDR_W'(XP_OUTPUTS));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      words_q <= '0;
    end else begin
      for (int i = 0; i < XP_OUTPUTS; i++)
        if (word_wr_en[i]) words_q[i] <= din;
    end
  end

  generate
    for (genvar g = 0; g < XP_OUTPUTS; g++) begin : g_chk
      p_load_r3: assert property (@(posedge clk) disable iff (!por_n)
        word_wr_en[g] |=> words_q[g] == $past(din));
      p_keep_r3: assert property (@(posedge clk) disable iff (!por_n)
        !word_wr_en[g] |=> $stable(words_q[g]));
    end
  endgenerate

  p_ignore_r4: assert property (@(posedge clk) disable iff (!por_n)
    (wr_strobe && addr_out_of_range) |=> $stable(words_q));
  p_idle_r2: assert property (@(posedge clk) disable iff (!por_n)
    ce_n |=> $stable(words_q));
endmodule

// File: rtl/xpt_stage_hold.sv
module xpt_stage_hold
  import xpt_pkg::*;
(
  input  logic                                   clk,
  input  logic                                   por_n,
  input  logic                                   off_n,
  input  logic                                   ce_n,
  input  logic                                   xfer_n,
  input  xp_word_t [XP_OUTPUTS-1:0]              staged,
  output logic [XP_OUTPUTS-1:0][XP_SEL_W-1:0]    sel_q,
  output logic [XP_OUTPUTS-1:0]                  en_q
);
  logic                                xfer_strobe;
  logic [XP_OUTPUTS-1:0]               staged_en;
  logic [XP_OUTPUTS-1:0][XP_SEL_W-1:0] staged_sel;

  assign xfer_strobe = ~ce_n & ~xfer_n;

  always_comb begin
    for (int i = 0; i < XP_OUTPUTS; i++) begin
      staged_en[i]  = staged[i].en;
      staged_sel[i] = staged[i].sel;
    end
  end

  // input selections: cleared only by power-on reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)           sel_q <= '0;
    else if (xfer_strobe) sel_q <= staged_sel;
  end

  // enables: also cleared at once by disable-all
  always_ff @(posedge clk or negedge por_n or negedge off_n) begin
    if (!por_n)           en_q <= '0;
    else if (!off_n)      en_q <= '0;
    else if (xfer_strobe) en_q <= staged_en;
  end

  p_xfer_sel_r5: assert property (@(posedge clk) disable iff (!por_n)
    xfer_strobe |=> sel_q == $past(staged_sel));
  p_xfer_en_r5: assert property (@(posedge clk) disable iff (!por_n || !off_n)
    xfer_strobe |=> en_q == $past(staged_en));
  p_hold_r6: assert property (@(posedge clk) disable iff (!por_n)
    !xfer_strobe |=> $stable(sel_q));
  p_clear_r9: assert property (@(posedge clk) disable iff (!por_n)
    !off_n |-> en_q == '0);
  p_stay_off_r10: assert property (@(posedge clk) disable iff (!por_n || !off_n)
    !xfer_strobe |=> $stable(en_q));
endmodule

// File: rtl/xpt_close_dec.sv
module xpt_close_dec
  import xpt_pkg::*;
(
  input  logic                                clk,
  input  logic                                por_n,
  input  logic [XP_OUTPUTS-1:0][XP_SEL_W-1:0] sel_q,
  input  logic [XP_OUTPUTS-1:0]               en_q,
  output logic [XP_CLOSE_W-1:0]               close
);
  generate
    for (genvar g = 0; g < XP_OUTPUTS; g++) begin : g_out
      xp_word_t w;
      assign w = {en_q[g], sel_q[g]};
      assign close[g*XP_INPUTS +: XP_INPUTS] = xp_close(w);

      p_onehot_r7: assert property (@(posedge clk) disable iff (!por_n)
        $onehot0(close[g*XP_INPUTS +: XP_INPUTS]));
      p_gate_r8: assert property (@(posedge clk) disable iff (!por_n)
        !en_q[g] |-> close[g*XP_INPUTS +: XP_INPUTS] == '0);
    end
  endgenerate
endmodule

// File: rtl/xpt_ctrl.sv
module xpt_ctrl
  import xpt_pkg::*;
(
  input  logic                    clk,
  input  logic                    por_n,
  input  logic                    off_n,
  input  logic                    ce_n,
  input  logic                    xfer_n,
  input  logic [XP_ADDR_W-1:0]    addr,
  input  logic [XP_WORD_W-1:0]    din,
  output logic [XP_CLOSE_W-1:0]   close,
  output logic [XP_OUTPUTS-1:0]   out_en
);
  xp_word_t                            din_w;
  xp_word_t [XP_OUTPUTS-1:0]           staged;
  logic [XP_OUTPUTS-1:0][XP_SEL_W-1:0] act_sel;
  logic [XP_OUTPUTS-1:0]               act_en;

  assign din_w  = din;
  assign out_en = act_en;

  xpt_stage_wr u_wr (
    .clk(clk), .por_n(por_n), .ce_n(ce_n), .xfer_n(xfer_n),
    .addr(addr), .din(din_w), .words_q(staged)
  );

  xpt_stage_hold u_hold (
    .clk(clk), .por_n(por_n), .off_n(off_n), .ce_n(ce_n), .xfer_n(xfer_n),
    .staged(staged), .sel_q(act_sel), .en_q(act_en)
  );

  xpt_close_dec u_dec (
    .clk(clk), .por_n(por_n), .sel_q(act_sel), .en_q(act_en), .close(close)
  );

  p_por_r1: assert property (@(posedge clk)
    !por_n |-> (out_en == '0 && close == '0));
endmodule

// File: tb/sim_xpt_ctrl.sv
`timescale 1ns/1ps
module sim_xpt_ctrl;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, off_n = 1'b1, ce_n = 1'b1, xfer_n = 1'b1;
  logic [2:0]  addr = '0;
  logic [4:0]  din = '0;
  logic [79:0] close;
  logic [4:0]  out_en;

  int checks = 0, fails = 0;
  string phase = "R1";
  int m1_sel[5], m1_en[5], m2_sel[5], m2_en[5];

  always #10 clk = ~clk;

  xpt_ctrl u0 (.clk(clk), .por_n(por_n), .off_n(off_n), .ce_n(ce_n),
               .xfer_n(xfer_n), .addr(addr), .din(din), .close(close), .out_en(out_en));

  // behavioural reference
  always @(posedge clk) begin
    if (por_n && !ce_n) begin
      if (xfer_n) begin
        if (addr < 5) begin m1_sel[addr] = din[3:0]; m1_en[addr] = din[4]; end
      end else begin
        for (int k = 0; k < 5; k++) begin
          m2_sel[k] = m1_sel[k];
          m2_en[k]  = off_n ? m1_en[k] : 0;
        end
      end
    end
  end

  task automatic model_clear_all();
    for (int k = 0; k < 5; k++) begin m1_sel[k]=0; m1_en[k]=0; m2_sel[k]=0; m2_en[k]=0; end
  endtask

  task automatic chk(string tag, logic [84:0] act, logic [84:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    logic [84:0] e;
    #2;
    if (por_n) begin
      e = '0;
      for (int k = 0; k < 5; k++) begin
        e[80+k] = (m2_en[k] != 0);
        if (m2_en[k] != 0) e[16*k + m2_sel[k]] = 1'b1;
      end
      chk(phase, {out_en, close}, e);
    end
  end

  task automatic cyc(bit c, bit x, logic [2:0] a, logic [4:0] d);
    @(negedge clk);
    ce_n = c; xfer_n = x; addr = a; din = d;
  endtask

  task automatic settle();
    @(negedge clk); ce_n = 1'b1; xfer_n = 1'b1;
    @(negedge clk); #3;
  endtask

  initial begin
    #(20.0 * 200000);
    fails++;
    $display("FAIL watchdog expired in phase %s", phase);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [84:0] e;
    model_clear_all();
    repeat (3) @(negedge clk);
    #3 chk("R1", {out_en, close}, '0);
    @(negedge clk); por_n = 1'b1;

    // R3 writes, R6 active rank holds
    phase = "R3";
    cyc(0, 1, 3'd0, 5'b1_0011);
    cyc(0, 1, 3'd1, 5'b1_1111);
    cyc(0, 1, 3'd4, 5'b1_0000);
    settle();
    chk("R6", {out_en, close}, '0);

    // R5 transfer
    phase = "R5";
    cyc(0, 0, 3'd0, 5'b0);
    settle();
    e = '0; e[84:80] = 5'b10011; e[3] = 1; e[16+15] = 1; e[64] = 1;
    chk("R5", {out_en, close}, e);

    // R2 chip select high blocks write and transfer
    phase = "R2";
    cyc(1, 1, 3'd0, 5'b1_0111);
    cyc(1, 0, 3'd0, 5'b0);
    settle();
    chk("R2", {out_en, close}, e);
    cyc(0, 0, 3'd0, 5'b0);
    settle();
    chk("R2", {out_en, close}, e);

    // R4 ignored addresses
    phase = "R4";
    for (int a = 5; a < 8; a++) cyc(0, 1, 3'(a), 5'b1_1010);
    cyc(0, 0, 3'd0, 5'b0);
    settle();
    chk("R4", {out_en, close}, e);

    // R8 disabled output gives no closures
    phase = "R8";
    cyc(0, 1, 3'd1, 5'b0_0101);
    cyc(0, 0, 3'd0, 5'b0);
    settle();
    e = '0; e[84:80] = 5'b10001; e[3] = 1; e[64] = 1;
    chk("R8", {out_en, close}, e);

    // R9 asynchronous disable-all, mid-cycle
    phase = "R9";
    @(posedge clk); #5;
    off_n = 1'b0;
    for (int k = 0; k < 5; k++) m2_en[k] = 0;
    #1 chk("R9", {out_en, close}, '0);
    cyc(0, 0, 3'd0, 5'b0);
    cyc(1, 1, 3'd0, 5'b0);
    @(negedge clk); off_n = 1'b1;

    // R10 stays off until a transfer
    phase = "R10";
    repeat (4) @(negedge clk);
    #3 chk("R10", {out_en, close}, '0);
    cyc(0, 0, 3'd0, 5'b0);
    settle();
    chk("R9", {out_en, close}, e);   // staged words were kept

    // R7 every input number on output 3
    phase = "R7";
    for (int s = 0; s < 16; s++) begin
      cyc(0, 1, 3'd3, {1'b1, 4'(s)});
      cyc(0, 0, 3'd0, 5'b0);
      settle();
      e = '0; e[84:80] = 5'b11001; e[3] = 1; e[64] = 1; e[48 + s] = 1;
      chk("R7", {out_en, close}, e);
    end

    // mixed traffic against the model
    phase = "R5";
    for (int i = 0; i < 400; i++)
      cyc(($urandom % 4) == 0, ($urandom % 3) == 0, 3'($urandom % 8), 5'($urandom % 32));
    settle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule